// File: doc/BRIEF.md
# Watchdog timer with prescaler

This block is the watchdog timer of a small microcontroller core. It counts events from one of two sources and raises a one-cycle timeout when the count overflows. The core uses that timeout as a reset request. A configuration input picks the source. The first source is a low-speed oscillator tick, which is asynchronous and is brought into the system clock domain before use. The second source is the instruction clock, which is one event every four system clock cycles. The chosen events pass through a fixed binary divider and then a power-of-two prescaler. A byte-wide control register sets the prescaler ratio.

Software keeps the timer from expiring by pulsing a clear strobe. When the block is disabled it does nothing at all. When the core halts, the instruction-clock source stops, because the system clock it is derived from stops. The oscillator source keeps running through halt, so the watchdog still protects the core while it is halted.

Top module: `wdog_prescaled`

## Requirements
- R1: With `src_osc_i`=1, each rising edge of `osc_tick_i` counts once, after a two-flop synchronizer and an edge detector. With `src_osc_i`=0, the block counts one event every 4 system clock cycles.
- R2: Counted events pass first through a fixed divider of 2^FIX_STAGES (256 by default), and only then reach the prescaler.
- R3: Control bits [2:0] hold the prescaler select `s`, which gives a ratio of 2^s. A timeout therefore needs 2^FIX_STAGES × 2^s counted events. With `s`=7 (111) this is 32768 events, the longest interval.
- R4: `timeout_o` is high for exactly one cycle per overflow. The whole chain then restarts from zero, so timeouts repeat at the interval of R3. After reset, `timeout_o` is 0.
- R5: `clr_i` sampled high while `en_i`=1 zeroes the divider, the prescaler and the instruction-clock phase. With the instruction source, the next timeout then appears 4 × 2^FIX_STAGES × 2^s cycles after that edge.
- R6: If a clear and the overflowing event fall on the same edge, the clear wins and no timeout is produced. A full new interval then starts from that edge.
- R7: While `en_i`=0, no timeout is produced, `clr_i` has no effect, and the chain and phase are held at zero. After `en_i` rises, counting starts from zero.
- R8: With the instruction source, `halt_i`=1 freezes the phase and the chain. Counting resumes from the frozen state when `halt_i` falls.
- R9: With the oscillator source, `halt_i` has no effect on counting or on the timeout interval.
- R10: The control register resets to 8'h07. A write stores the whole byte, and every bit reads back as written. Bits [7:3] have no effect on the timer.
- R11: A write to the select field applies from the next counted event. It does not clear the count already accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Watchdog enable configuration bit |
| src_osc_i | input | 1 | Count source: 1 = oscillator tick, 0 = instruction clock |
| halt_i | input | 1 | Core is halted / powered down |
| osc_tick_i | input | 1 | Asynchronous low-speed oscillator tick |
| clr_i | input | 1 | Software clear strobe |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| timeout_o | output | 1 | One-cycle timeout reset request |

## Verification
The clear strobe and the overflowing event can land on the same clock edge. In that case the clear must suppress the timeout pulse and restart the interval. The bench provokes this with the instruction source: it times a clear so that it is sampled on the exact edge that consumes the final counted event. It then checks that `timeout_o` stays low on that cycle and that the next pulse arrives one full interval after that edge. A second coincidence is a select write landing in the middle of an interval. That case is judged by the arrival time of the next pulse, which must reflect the new ratio without any loss of the count already reached.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CTL_W = 8;

  typedef enum logic {
    SRC_INSTR = 1'b0,
    SRC_OSC   = 1'b1
  } wdog_src_e;
endpackage

// File: rtl/wdog_src_sel.sv
module wdog_src_sel #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PHASE_W     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic halt_i,
  input  logic src_osc_i,
  input  logic osc_tick_i,
  output logic cnt_en_o
);
  localparam int unsigned SMSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [PHASE_W-1:0]     phase_q;
  logic                   osc_pulse;
  logic                   instr_pulse;

  // synchronizer and edge detector for the oscillator tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SMSB-1:0], osc_tick_i};
      prev_q <= sync_q[SMSB];
    end
  end

  assign osc_pulse = sync_q[SMSB] & ~prev_q;

  // instruction clock phase: frozen in halt, since the system clock stops there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (!en_i || clr_i) begin
      phase_q <= '0;
    end else if (!halt_i) begin
      phase_q <= phase_q + PHASE_W'(1);
    end
  end

  assign instr_pulse = (&phase_q) & ~halt_i;
  assign cnt_en_o    = en_i & (src_osc_i ? osc_pulse : instr_pulse);
endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
  parameter int unsigned FIX_STAGES = 8,
  parameter int unsigned SEL_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             timeout_o
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 1;

  logic [FIX_STAGES-1:0] fix_q;
  logic [PRE_W-1:0]      pre_q;
  logic [PRE_W-1:0]      sel_mask;
  logic                  fix_wrap;
  logic                  term;
  logic                  to_q;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign sel_mask[i] = (int'(sel_i) > i);
  end

  assign fix_wrap = cnt_en_i & (&fix_q);
  assign term     = fix_wrap & ((pre_q & sel_mask) == sel_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fix_q <= '0;
      pre_q <= '0;
      to_q  <= 1'b0;
    end else if (clr_i) begin
      fix_q <= '0;
      pre_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= term;
      if (term) begin
        fix_q <= '0;
        pre_q <= '0;
      end else if (cnt_en_i) begin
        fix_q <= fix_q + FIX_STAGES'(1);
        if (fix_wrap) pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg #(
  parameter int unsigned       W       = 8,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (we_i) q <= wdata_i;
  end

  assign rdata_o = q;
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int unsigned FIX_STAGES  = 8,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PHASE_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_osc_i,
  input  logic             halt_i,
  input  logic             osc_tick_i,
  input  logic             clr_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  output logic             timeout_o
);
  localparam logic [CTL_W-1:0] CTL_RST = CTL_W'((1 << SEL_W) - 1);

  logic             use_osc;
  logic             cnt_en;
  logic             chain_clr;
  logic [CTL_W-1:0] ctl_q;

  assign use_osc   = (wdog_src_e'(src_osc_i) == SRC_OSC);
  assign chain_clr = ~en_i | clr_i;

  wdog_ctl_reg #(
    .W       (CTL_W),
    .RST_VAL (CTL_RST)
  ) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .rdata_o (ctl_q)
  );

  wdog_src_sel #(
    .SYNC_STAGES (SYNC_STAGES),
    .PHASE_W     (PHASE_W)
  ) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .clr_i      (clr_i),
    .halt_i     (halt_i),
    .src_osc_i  (use_osc),
    .osc_tick_i (osc_tick_i),
    .cnt_en_o   (cnt_en)
  );

  wdog_chain #(
    .FIX_STAGES (FIX_STAGES),
    .SEL_W      (SEL_W)
  ) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (chain_clr),
    .cnt_en_i  (cnt_en),
    .sel_i     (ctl_q[SEL_W-1:0]),
    .timeout_o (timeout_o)
  );

  assign ctl_rdata_o = ctl_q;
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk
  import wdog_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             src_osc_i,
  input logic             halt_i,
  input logic             clr_i,
  input logic             ctl_we_i,
  input logic [CTL_W-1:0] ctl_wdata_i,
  input logic [CTL_W-1:0] ctl_rdata_o,
  input logic             timeout_o,
  input logic             cnt_en
);
  assert_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  assert_off_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !timeout_o);

  assert_clr_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> !timeout_o);

  assert_halt_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && halt_i && !src_osc_i) |=> !timeout_o);

  assert_from_event_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(cnt_en));

  assert_rd_back_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (ctl_rdata_o == $past(ctl_wdata_i)));

  assert_ctl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(ctl_rdata_o));
endmodule

bind wdog_prescaled wdog_prescaled_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .src_osc_i   (src_osc_i),
  .halt_i      (halt_i),
  .clr_i       (clr_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .timeout_o   (timeout_o),
  .cnt_en      (cnt_en)
);

// File: tb/wdog_prescaled_tb_top.sv
`timescale 1ns/1ps
module wdog_prescaled_tb_top;
  // shortened fixed divider (2^4) keeps every ratio of both sources in budget
  localparam int unsigned FIX_TB = 4;
  localparam int          BASE   = 1 << FIX_TB;

  typedef struct packed {
    logic        src;
    logic [7:0]  ctl;
    int unsigned ivl;
  } vec_t;

  // instruction source: 4 cycles per event; oscillator: 6 cycles per event
  localparam vec_t VECS [16] = '{
    '{1'b0, 8'h00,   64}, '{1'b0, 8'h09,  128}, '{1'b0, 8'hA2,  256},
    '{1'b0, 8'h33,  512}, '{1'b0, 8'hF4, 1024}, '{1'b0, 8'h55, 2048},
    '{1'b0, 8'h86, 4096}, '{1'b0, 8'h7F, 8192},
    '{1'b1, 8'h08,   96}, '{1'b1, 8'h11,  192}, '{1'b1, 8'hC2,  384},
    '{1'b1, 8'h2B,  768}, '{1'b1, 8'h44, 1536}, '{1'b1, 8'hDD, 3072},
    '{1'b1, 8'h66, 6144}, '{1'b1, 8'hFF, 12288}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, src_osc, halt, osc_tick, clr, we;
  logic [7:0] wdata, rdata;
  logic       timeout;

  int  cyc = 0;
  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    osc_tick = 1'b0;
    #1;
    forever #15 osc_tick = ~osc_tick;
  end

  wdog_prescaled #(.FIX_STAGES(FIX_TB)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .src_osc_i   (src_osc),
    .halt_i      (halt),
    .osc_tick_i  (osc_tick),
    .clr_i       (clr),
    .ctl_we_i    (we),
    .ctl_wdata_i (wdata),
    .ctl_rdata_o (rdata),
    .timeout_o   (timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int lim, output int t);
    t = -1;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (timeout) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    we = 1'b1;
    wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  // returns the cycle count of the edge that sampled the clear
  task automatic do_clr(output int tc);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    tc = cyc;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int tc, t1, t2, n;
    rst_n = 1'b0; en = 1'b1; src_osc = 1'b0; halt = 1'b0;
    clr = 1'b0; we = 1'b0; wdata = 8'h00;
    repeat (5) @(negedge clk);
    chk("R4 reset timeout", int'(timeout), 0);
    chk("R10 reset value", int'(rdata), 8'h07);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 idle after reset", int'(timeout), 0);

    // table walk: every ratio with both sources (R1, R2, R3, R4, R5, R10)
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      src_osc = VECS[i].src;
      wr_ctl(VECS[i].ctl);
      chk("R10 read back", int'(rdata), int'(VECS[i].ctl));
      do_clr(tc);
      wait_to(2 * int'(VECS[i].ivl) + 100, t1);
      if (!VECS[i].src) chk("R5 clear to timeout", t1 - tc, int'(VECS[i].ivl));
      @(negedge clk);
      chk("R4 single cycle pulse", int'(timeout), 0);
      wait_to(2 * int'(VECS[i].ivl) + 100, t2);
      if (VECS[i].src) chk("R1 R2 R3 osc interval", t2 - t1, int'(VECS[i].ivl));
      else             chk("R2 R3 instr interval", t2 - t1, int'(VECS[i].ivl));
    end

    // R6: clear sampled on the edge of the final event
    src_osc = 1'b0;
    wr_ctl(8'h00);
    do_clr(tc);
    wait_until(tc + 4 * BASE - 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R6 clear beats overflow", int'(timeout), 0);
    wait_to(400, t1);
    chk("R6 restart interval", t1 - tc, 8 * BASE);

    // R11: ratio raised mid-interval keeps accumulated count
    wr_ctl(8'h00);
    do_clr(tc);
    wait_until(tc + 39);
    we = 1'b1;
    wdata = 8'h01;
    @(negedge clk);
    we = 1'b0;
    wait_to(400, t1);
    chk("R11 select change", t1 - tc, 8 * BASE);

    // R7: disabled, clears pulsed, no timeout; counting restarts from zero
    wr_ctl(8'h00);
    @(negedge clk);
    en = 1'b0;
    n = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      clr = (k % 100 == 50);
      if (timeout) n++;
    end
    clr = 1'b0;
    chk("R7 no timeout while off", n, 0);
    @(negedge clk);
    en = 1'b1;
    tc = cyc;
    wait_to(400, t1);
    chk("R7 start from zero", t1 - tc, 4 * BASE);

    // R8: instruction source frozen during halt, resumes where it stopped
    do_clr(tc);
    wait_until(tc + 19);
    halt = 1'b1;
    n = 0;
    while (cyc < tc + 1019) begin
      @(negedge clk);
      if (timeout) n++;
    end
    halt = 1'b0;
    chk("R8 no timeout in halt", n, 0);
    wait_to(400, t1);
    chk("R8 resume count", t1 - tc, 1064);

    // R9: oscillator source unaffected by halt
    src_osc = 1'b1;
    wr_ctl(8'h01);
    @(negedge clk);
    halt = 1'b1;
    do_clr(tc);
    wait_to(600, t1);
    wait_to(600, t2);
    chk("R9 osc interval in halt", t2 - t1, 192);
    halt = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule